// File: doc/BRIEF.md
# NEC Pulse-Distance Frame Decoder

This block turns one received infrared packet, given as a stream of run-length bytes, into a 32-bit NEC code. Each byte carries a level flag in bit 7 (1 = pulse, 0 = space) and a duration field in bits 6:0 that stands for field + 1 sample periods. A sampling front end streams the bytes over a valid/ready pair. It then raises a packet-end strobe when the line has gone idle.

The decoder works on the bytes as they arrive, with no packet buffer. It first finds the leader mark and the leader space. It then classifies each pulse and space pair as one data bit by its space length. Decoding stops after 32 bits. At packet end it gives the code, a one-cycle done strobe, an error flag and a valid flag. The valid flag compares only the command byte with its complement. After the strobe it is ready for the next packet.

Top module: `nec_rl_decoder`

## Requirements
- R1: After reset, done_o, err_o and code_valid_o are 0 and code_o is 0; tok_ready_o is 1 so every byte offered is taken.
- R2: Consecutive bytes of the same level form one run whose length is the sum of (field + 1) over its bytes.
- R3: The leader mark search starts with the run length preloaded to 80. The first space seen while the pulse run length exceeds 80 ends the mark; a space seen at 80 or less clears the length and the search goes on.
- R4: The leader space is a space run longer than 40 samples, closed by the next pulse; a pulse after a space run of 40 or less clears the length and the search goes on. A packet that ends before a leader mark and leader space are both found reports an error.
- R5: In the data phase a pulse run longer than 26 samples is an error.
- R6: A data space run longer than 26 samples decodes as 1, one of 26 or less as 0. A space run longer than 53 samples is an error. A space is judged when the following pulse byte arrives.
- R7: Data bits fill code bit 0 first, then upward. After the 32nd bit every further byte of the packet is ignored.
- R8: On any error, code_o is 0xFFFFFFFF and err_o is 1 (an empty packet is an error).
- R9: code_valid_o is 1 only when err_o is 0 and code bits 23:16 equal the bitwise inverse of bits 31:24; bits 15:0 (address) have no effect on it.
- R10: A packet end that comes before 32 bits are decoded reports the bits decoded so far, upper bits 0, with err_o 0.
- R11: done_o is high for exactly the one cycle after a packet-end strobe. A byte accepted in the same cycle as the strobe is part of that packet. The code and flags hold until the next strobe. Each packet starts from a fresh state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tok_valid_i | input | 1 | Run-length byte present |
| tok_ready_o | output | 1 | Byte accepted (always 1) |
| tok_byte_i | input | 8 | Bit 7 level (1 pulse), bits 6:0 duration minus one |
| pkt_end_i | input | 1 | Packet-end strobe |
| done_o | output | 1 | One-cycle result strobe |
| code_o | output | 32 | Decoded code, all ones on error |
| code_valid_o | output | 1 | Command byte matches its complement |
| err_o | output | 1 | Packet failed decoding |

## Verification
Two functions can act in the same cycle: taking a byte and closing the packet. The case that matters is when that byte is the trailing pulse that finishes the 32nd bit. The bench sends the last byte together with the strobe in some packets and one or more cycles later in others. Random idle gaps sit between bytes. Each result is compared with a bench model that decodes the whole byte list, so a byte lost or counted twice at the boundary shows up as a wrong code or a 31-bit partial.

// File: rtl/nec_rl_pkg.sv
// Shared types for the run-length NEC decoder.
// Assumes: one packet at a time; states are private to the decoder.
package nec_rl_pkg;
    localparam int CODE_W = 32;

    typedef enum logic [2:0] {
        ST_MARK   = 3'd0,  // looking for the leader pulse run
        ST_LSPACE = 3'd1,  // looking for the leader space run
        ST_PULSE  = 3'd2,  // inside a data pulse run
        ST_SPACE  = 3'd3,  // inside a data space run
        ST_FULL   = 3'd4,  // all bits decoded, rest ignored
        ST_FAIL   = 3'd5   // decoding error latched
    } dec_st_e;
endpackage

// File: rtl/nec_rl_step.sv
// Combinational next-state logic for one run-length byte.
// Assumes: the accumulator saturates, and thresholds are far below
// its ceiling. The byte that ends a phase opens the next phase's run.
module nec_rl_step
    import nec_rl_pkg::*;
#(
    parameter int ACC_W     = 12,
    parameter int MARK_MIN  = 80,
    parameter int LSP_MIN   = 40,
    parameter int PULSE_MAX = 26,
    parameter int BIT1_MIN  = 26,
    parameter int SPACE_MAX = 53,
    localparam int BIT_W    = $clog2(CODE_W),
    localparam int CNT_W    = BIT_W + 1
) (
    input  dec_st_e            st_i,
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [CODE_W-1:0]  code_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               tok_valid_i,
    input  logic [7:0]         tok_byte_i,
    output dec_st_e            st_o,
    output logic [ACC_W-1:0]   acc_o,
    output logic [CODE_W-1:0]  code_o,
    output logic [CNT_W-1:0]   cnt_o
);
    logic             is_pulse;
    logic [ACC_W-1:0] dur;
    logic [ACC_W:0]   sum_wide;
    logic [ACC_W-1:0] sum;

    // Byte duration in samples and saturating run sum.
    always_comb begin
        is_pulse = tok_byte_i[7];
        dur      = ACC_W'(tok_byte_i[6:0]) + ACC_W'(1);
        sum_wide = {1'b0, acc_i} + {1'b0, dur};
        sum      = sum_wide[ACC_W] ? '1 : sum_wide[ACC_W-1:0];
    end

    // Phase walk: extend the current run or close it and judge it.
    always_comb begin
        st_o   = st_i;
        acc_o  = acc_i;
        code_o = code_i;
        cnt_o  = cnt_i;
        if (tok_valid_i) begin
            unique case (st_i)
                ST_MARK: begin
                    if (is_pulse)                          acc_o = sum;
                    else if (acc_i > ACC_W'(MARK_MIN)) begin
                        st_o  = ST_LSPACE;
                        acc_o = dur;
                    end else                               acc_o = '0;
                end
                ST_LSPACE: begin
                    if (!is_pulse)                         acc_o = sum;
                    else if (acc_i > ACC_W'(LSP_MIN)) begin
                        st_o  = ST_PULSE;
                        acc_o = dur;
                    end else                               acc_o = '0;
                end
                ST_PULSE: begin
                    if (is_pulse)                          acc_o = sum;
                    else if (acc_i > ACC_W'(PULSE_MAX))    st_o = ST_FAIL;
                    else begin
                        st_o  = ST_SPACE;
                        acc_o = dur;
                    end
                end
                ST_SPACE: begin
                    if (!is_pulse)                         acc_o = sum;
                    else if (acc_i > ACC_W'(SPACE_MAX))    st_o = ST_FAIL;
                    else begin
                        code_o[cnt_i[BIT_W-1:0]] = (acc_i > ACC_W'(BIT1_MIN));
                        cnt_o = cnt_i + CNT_W'(1);
                        acc_o = dur;
                        st_o  = (cnt_i == CNT_W'(CODE_W - 1)) ? ST_FULL : ST_PULSE;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nec_rl_judge.sv
// Turns the end-of-packet decoder state into the reported result.
// Assumes: only data-phase or full states carry a usable code.
module nec_rl_judge
    import nec_rl_pkg::*;
(
    input  dec_st_e            st_i,
    input  logic [CODE_W-1:0]  code_i,
    output logic [CODE_W-1:0]  code_o,
    output logic               err_o,
    output logic               valid_o
);
    localparam int CMD_HI = CODE_W - 1;
    localparam int CMD_LO = CODE_W - 8;
    localparam int INV_HI = CODE_W - 9;
    localparam int INV_LO = CODE_W - 16;

    // Error class, error substitution and command-byte check.
    always_comb begin
        err_o   = !(st_i == ST_PULSE || st_i == ST_SPACE || st_i == ST_FULL);
        code_o  = err_o ? '1 : code_i;
        valid_o = !err_o && (code_o[INV_HI:INV_LO] == ~code_o[CMD_HI:CMD_LO]);
    end
endmodule

// File: rtl/nec_rl_decoder.sv
// NEC frame decoder fed by run-length bytes.
// Holds the walk state between bytes and registers the result on a
// packet-end strobe. Assumes one byte per cycle at most and no backpressure.
module nec_rl_decoder
    import nec_rl_pkg::*;
#(
    parameter int ACC_W     = 12,
    parameter int MARK_MIN  = 80,
    parameter int LSP_MIN   = 40,
    parameter int PULSE_MAX = 26,
    parameter int BIT1_MIN  = 26,
    parameter int SPACE_MAX = 53,
    localparam int CNT_W    = $clog2(CODE_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid_i,
    output logic              tok_ready_o,
    input  logic [7:0]        tok_byte_i,
    input  logic              pkt_end_i,
    output logic              done_o,
    output logic [CODE_W-1:0] code_o,
    output logic              code_valid_o,
    output logic              err_o
);
    dec_st_e            st_q, st_d;
    logic [ACC_W-1:0]   acc_q, acc_d;
    logic [CODE_W-1:0]  code_q, code_d, fin_code;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               fin_err, fin_valid;

    assign tok_ready_o = 1'b1;

    nec_rl_step #(
        .ACC_W(ACC_W), .MARK_MIN(MARK_MIN), .LSP_MIN(LSP_MIN),
        .PULSE_MAX(PULSE_MAX), .BIT1_MIN(BIT1_MIN), .SPACE_MAX(SPACE_MAX)
    ) u_step (
        .st_i(st_q), .acc_i(acc_q), .code_i(code_q), .cnt_i(cnt_q),
        .tok_valid_i(tok_valid_i), .tok_byte_i(tok_byte_i),
        .st_o(st_d), .acc_o(acc_d), .code_o(code_d), .cnt_o(cnt_d)
    );

    nec_rl_judge u_judge (
        .st_i(st_d), .code_i(code_d),
        .code_o(fin_code), .err_o(fin_err), .valid_o(fin_valid)
    );

    // Walk state: advance per byte, restart on packet end.
    always_ff @(posedge clk) begin
        if (!rst_n || pkt_end_i) begin
            st_q   <= ST_MARK;
            acc_q  <= ACC_W'(MARK_MIN);
            code_q <= '0;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            acc_q  <= acc_d;
            code_q <= code_d;
            cnt_q  <= cnt_d;
        end
    end

    // Result registers: load on packet end, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o       <= 1'b0;
            code_o       <= '0;
            code_valid_o <= 1'b0;
            err_o        <= 1'b0;
        end else begin
            done_o <= pkt_end_i;
            if (pkt_end_i) begin
                code_o       <= fin_code;
                code_valid_o <= fin_valid;
                err_o        <= fin_err;
            end
        end
    end
endmodule

// File: rtl/nec_rl_decoder_chk.sv
// Property checker for nec_rl_decoder, attached by bind.
module nec_rl_decoder_chk #(
    parameter int CNT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_end_i,
    input logic              done_o,
    input logic [31:0]       code_o,
    input logic              code_valid_o,
    input logic              err_o,
    input logic [CNT_W-1:0]  cnt_q
);
    AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(pkt_end_i));                                  // R11
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_end_i |=> $stable(code_o) && $stable(err_o) && $stable(code_valid_o)); // R11
    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (code_o == 32'hFFFF_FFFF));                         // R8
    AST_VALID_CMD_INV: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid_o |-> (!err_o && code_o[23:16] == ~code_o[31:24])); // R9
    AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(32));                                          // R7
endmodule

bind nec_rl_decoder nec_rl_decoder_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_end_i(pkt_end_i), .done_o(done_o),
    .code_o(code_o), .code_valid_o(code_valid_o), .err_o(err_o),
    .cnt_q(cnt_q)
);

// File: tb/nec_rl_decoder_bench.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random frames, checked against a
// whole-packet reference decoder written as a bench function.
module nec_rl_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid_i = 1'b0;
    logic        tok_ready_o;
    logic [7:0]  tok_byte_i = 8'h00;
    logic        pkt_end_i = 1'b0;
    logic        done_o;
    logic [31:0] code_o;
    logic        code_valid_o;
    logic        err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] pkt [0:1023];
    int pkt_n = 0;

    always #2 clk = ~clk;

    nec_rl_decoder u_nec_rl_decoder (
        .clk(clk), .rst_n(rst_n), .tok_valid_i(tok_valid_i),
        .tok_ready_o(tok_ready_o), .tok_byte_i(tok_byte_i),
        .pkt_end_i(pkt_end_i), .done_o(done_o), .code_o(code_o),
        .code_valid_o(code_valid_o), .err_o(err_o)
    );

    // Reference: returns {err, code} for the current byte list.
    function automatic logic [32:0] model(int n);
        int i = 0; int len = 80; int bc = 0; int d;
        bit brk = 0; bit last = 1;
        logic [7:0] v;
        logic [31:0] code = '0;
        while (i < n && !brk) begin
            v = pkt[i];
            if (v[7]) begin len += int'(v[6:0]) + 1; i++; end
            else if (len > 80) brk = 1;
            else begin len = 0; i++; end
        end
        if (!brk) return {1'b1, 32'hFFFF_FFFF};
        len = 0; brk = 0;
        while (i < n && !brk) begin
            v = pkt[i];
            if (v[7]) begin
                if (len > 40) brk = 1;
                else begin len = 0; i++; end
            end else begin len += int'(v[6:0]) + 1; i++; end
        end
        if (!brk) return {1'b1, 32'hFFFF_FFFF};
        len = 0;
        for (; i < n; i++) begin
            v = pkt[i];
            d = int'(v[6:0]) + 1;
            if (last) begin
                if (v[7]) len += d;
                else begin
                    if (len > 26) return {1'b1, 32'hFFFF_FFFF};
                    last = 0; len = d;
                end
            end else begin
                if (v[7]) begin
                    if (len > 53) return {1'b1, 32'hFFFF_FFFF};
                    if (len > 26) code[bc] = 1'b1;
                    bc++;
                    if (bc == 32) break;
                    last = 1; len = d;
                end else len += d;
            end
        end
        return {1'b0, code};
    endfunction

    task automatic add_run(bit lvl, int len, bit split);
        while (len > 0) begin
            int cap = (len > 128) ? 128 : len;
            int piece = split ? 1 + int'($urandom % cap) : cap;
            if (pkt_n < 1024) begin
                pkt[pkt_n] = {lvl, 7'(piece - 1)};
                pkt_n++;
            end
            len -= piece;
        end
    endtask

    task automatic frame(logic [31:0] code, int lm, int ls, int pw,
                         int s0, int s1, bit split);
        add_run(1'b1, lm, split);
        add_run(1'b0, ls, split);
        for (int b = 0; b < 32; b++) begin
            add_run(1'b1, pw, split);
            add_run(1'b0, code[b] ? s1 : s0, split);
        end
        add_run(1'b1, pw, split);
    endtask

    task automatic std_frame(logic [31:0] code);
        pkt_n = 0;
        frame(code, 211, 105, 13, 13, 39, 1'b0);
    endtask

    // Send the packet, compare the result, then confirm done drops.
    task automatic run_pkt(string tag, bit with_last, bit gaps);
        logic [32:0] exp = model(pkt_n);
        logic exp_valid = !exp[32] && (exp[23:16] == ~exp[31:24]);
        bit wl = with_last && (pkt_n > 0);
        for (int i = 0; i < pkt_n; i++) begin
            if (gaps) repeat ($urandom % 3) begin
                @(negedge clk); tok_valid_i = 1'b0; pkt_end_i = 1'b0;
            end
            @(negedge clk);
            tok_valid_i = 1'b1;
            tok_byte_i  = pkt[i];
            pkt_end_i   = wl && (i == pkt_n - 1);
        end
        @(negedge clk);
        tok_valid_i = 1'b0;
        if (wl) pkt_end_i = 1'b0;
        else begin
            pkt_end_i = 1'b1;
            @(negedge clk);
            pkt_end_i = 1'b0;
        end
        n_chk++;
        if (done_o !== 1'b1 || code_o !== exp[31:0] || err_o !== exp[32] ||
            code_valid_o !== exp_valid) begin
            n_bad++;
            $display("FAIL %s: done=%0b code=%08h err=%0b valid=%0b expected done=1 code=%08h err=%0b valid=%0b",
                     tag, done_o, code_o, err_o, code_valid_o, exp[31:0], exp[32], exp_valid);
        end
        @(negedge clk);
        n_chk++;
        if (done_o !== 1'b0 || code_o !== exp[31:0]) begin
            n_bad++;
            $display("FAIL R11 after %s: done=%0b code=%08h expected done=0 code=%08h",
                     tag, done_o, code_o, exp[31:0]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        n_chk++;
        if (done_o !== 0 || err_o !== 0 || code_valid_o !== 0 || code_o !== 0 || tok_ready_o !== 1) begin
            n_bad++;
            $display("FAIL R1: done=%0b err=%0b valid=%0b code=%08h ready=%0b expected 0 0 0 00000000 1",
                     done_o, err_o, code_valid_o, code_o, tok_ready_o);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R7: bit order, good command pair
        std_frame(32'hE11E_A503); run_pkt("R7 order", 1'b0, 1'b0);
        // R7: trailing bytes after 32 bits are ignored
        std_frame(32'h10EF_0001); add_run(1'b1, 100, 0); add_run(1'b0, 120, 0);
        run_pkt("R7 extra", 1'b0, 1'b0);
        // R2: split runs
        pkt_n = 0; frame(32'h7F80_1234, 211, 105, 13, 13, 39, 1'b1);
        run_pkt("R2 split", 1'b0, 1'b1);
        pkt_n = 0; add_run(1'b0, 10, 0); add_run(1'b1, 50, 0); add_run(1'b1, 50, 0);
        frame(32'h01FE_0000, 0, 100, 13, 13, 39, 1'b0);
        run_pkt("R2 sum", 1'b0, 1'b0);
        // R3: preload lets a 1-sample first pulse pass
        pkt_n = 0; frame(32'hC33C_5555, 1, 100, 13, 13, 39, 1'b0);
        run_pkt("R3 preload", 1'b0, 1'b0);
        // R3: mark of 80 after a reset space fails, 81 passes
        pkt_n = 0; add_run(1'b0, 10, 0); frame(32'hC33C_5555, 80, 100, 13, 13, 39, 1'b0);
        run_pkt("R3 mark80", 1'b0, 1'b0);
        pkt_n = 0; add_run(1'b0, 10, 0); frame(32'hC33C_5555, 81, 100, 13, 13, 39, 1'b0);
        run_pkt("R3 mark81", 1'b0, 1'b0);
        // R4: leader space 40 fails, 41 passes
        pkt_n = 0; frame(32'hA55A_0F0F, 211, 40, 13, 13, 39, 1'b0);
        run_pkt("R4 space40", 1'b0, 1'b0);
        pkt_n = 0; frame(32'hA55A_0F0F, 211, 41, 13, 13, 39, 1'b0);
        run_pkt("R4 space41", 1'b0, 1'b0);
        // R5: data pulse 26 passes, 27 fails
        pkt_n = 0; frame(32'h6699_1111, 211, 105, 26, 13, 39, 1'b0);
        run_pkt("R5 pulse26", 1'b0, 1'b0);
        pkt_n = 0; frame(32'h6699_1111, 211, 105, 27, 13, 39, 1'b0);
        run_pkt("R5 pulse27", 1'b0, 1'b0);
        // R6: 26 is zero, 27 is one, 53 is one, 54 fails
        pkt_n = 0; frame(32'h0000_0000, 211, 105, 13, 26, 39, 1'b0);
        run_pkt("R6 space26", 1'b0, 1'b0);
        pkt_n = 0; frame(32'hFFFF_FFFF, 211, 105, 13, 13, 27, 1'b0);
        run_pkt("R6 space27", 1'b0, 1'b0);
        pkt_n = 0; frame(32'hFFFF_FFFF, 211, 105, 13, 13, 53, 1'b0);
        run_pkt("R6 space53", 1'b0, 1'b0);
        pkt_n = 0; frame(32'hFFFF_FFFF, 211, 105, 13, 13, 54, 1'b0);
        run_pkt("R6 space54", 1'b0, 1'b0);
        // R8: empty packet
        pkt_n = 0; run_pkt("R8 empty", 1'b0, 1'b0);
        // R9: address ignored, command mismatch invalid
        std_frame(32'h38C7_FFFF); run_pkt("R9 addr", 1'b0, 1'b0);
        std_frame(32'h38C6_0000); run_pkt("R9 mismatch", 1'b0, 1'b0);
        // R10: early end after part of the data
        std_frame(32'h00FF_03FF); pkt_n = 2 + 2 * 10 + 1; run_pkt("R10 partial", 1'b0, 1'b0);
        // R11: last byte together with the strobe, then back to back
        std_frame(32'h9966_ABCD); run_pkt("R11 same cycle", 1'b1, 1'b0);
        std_frame(32'h9966_ABCD); run_pkt("R11 back to back", 1'b1, 1'b0);

        // Random frames with perturbation, truncation and trailing bytes
        for (int k = 0; k < 60; k++) begin
            logic [31:0] c = $urandom;
            if ($urandom % 2) c[23:16] = ~c[31:24];
            pkt_n = 0;
            frame(c, 150 + int'($urandom % 100), 30 + int'($urandom % 90),
                  5 + int'($urandom % 24), 5 + int'($urandom % 22),
                  27 + int'($urandom % 30), bit'($urandom % 2));
            if ($urandom % 4 == 0) pkt[$urandom % pkt_n] = 8'($urandom);
            if ($urandom % 6 == 0) pkt_n = int'($urandom % pkt_n);
            if ($urandom % 6 == 0) add_run(bit'($urandom % 2), 1 + int'($urandom % 200), 1'b1);
            run_pkt("R2 R5 R6 R8 R9 random", bit'($urandom % 2), bit'($urandom % 2));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule